// File: doc/BRIEF.md
# Two-Stage Programmable Clock Divider Channel

This block divides a fast clock by a programmable ratio using two chained counting stages. All logic runs in the fast clock domain, and no clock is derived from another. Each stage alternates its output level. It holds each level for a programmed number of advances, with separate low and high lengths. Stage one advances on every fast clock cycle. Stage two advances only on the cycles in which stage one's level rises. The channel output is the level of the last stage. A companion pulse, `div_rise`, gives downstream logic a clock enable in the cycle whose closing edge raises the output.

Either stage can be bypassed, and each stage has its own level to start from. A synchronous restart input returns both stages to their start levels. A control bit makes the channel ignore that restart. A hold mode drives the output to a static level. The hold mode works only while restart is being ignored. The stage count and the length-field width are parameters.

Top module: `casc_clk_divider`

## Requirements
- R1: A counting stage holds its level low for (L+1) of its advances, where L is its low-length field. Stage k uses bits [4k+3:4k] of `low_len`, counting k from 0.
- R2: A counting stage holds its level high for (H+1) of its advances, where H is its high-length field. Stage k uses bits [4k+3:4k] of `high_len`.
- R3: Stage one advances every cycle. Stage two advances once per rise of stage one. The output period is therefore (L1+H1+2)*(L2+H2+2) cycles, and the output is high for (H2+1)*(L1+H1+2) of them.
- R4: During reset, and in the cycle after a restart, each stage sits at its start level. Bit k of `start_level` applies to stage k, with 1 meaning high.
- R5: While `sync_in` is 1 and `sync_ignore` is 0, both stages stay at their start levels. Counting resumes at the first clock edge after `sync_in` falls.
- R6: With `sync_ignore` at 1, `sync_in` has no effect on the output.
- R7: With both `sync_ignore` and `hold_en` at 1, `div_out` equals `hold_level` and `div_rise` stays 0. When `sync_ignore` is 0, `hold_en` has no effect.
- R8: When bit 0 of `stage_bypass` is set, stage one's counter is idle and stage two advances every cycle. The output period is then (L2+H2+2).
- R9: A bypassed last stage toggles its level on every advance. With stage one counting, this gives a period of 2*(L1+H1+2) and a high time of (L1+H1+2). With both stages bypassed, the output toggles every cycle.
- R10: `div_rise` is 1 exactly in the cycle whose closing edge takes `div_out` from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | Synchronous restart request |
| sync_ignore | input | 1 | 1: ignore `sync_in`; also enables hold mode |
| hold_en | input | 1 | Request a static output (effective only with `sync_ignore`) |
| hold_level | input | 1 | Static level driven while holding |
| low_len | input | NUM_STAGES*CNT_W | Per-stage low length minus one |
| high_len | input | NUM_STAGES*CNT_W | Per-stage high length minus one |
| start_level | input | NUM_STAGES | Per-stage level after reset or restart |
| stage_bypass | input | NUM_STAGES | Per-stage bypass |
| div_out | output | 1 | Divided output level |
| div_rise | output | 1 | Pulse in the cycle before `div_out` rises |

## Verification
The bench targets the extremes of the length fields. All-zero fields give the shortest period. All-ones fields give a period of 1024 cycles, which would expose a counter that wraps or a comparison that is off by one. Asymmetric settings separate the low length from the high length, so swapped fields would show up as a high time that does not match the low time. The bypass cases check whether stage two advances on stage one's rises or on every cycle; a mistake there multiplies or divides the measured period. Directed tests check the following:
- The first high interval after a restart with a high start level. A design that counted the start cycle wrongly would give 12 or 14 cycles instead of 13.
- A restart that is ignored.
- A hold request without the ignore bit, which must not freeze the output.

// File: rtl/casc_div_pkg.sv
package casc_div_pkg;
   // smallest length field the stage logic supports
   localparam int unsigned MIN_LEN_W   = 1;
   // smallest cascade depth
   localparam int unsigned MIN_STAGES  = 1;

   // low bit of stage idx inside a packed per-stage field vector
   function automatic int unsigned fld_lsb(input int unsigned idx, input int unsigned w);
      return idx * w;
   endfunction
endpackage

// File: rtl/casc_div_stage.sv
module casc_div_stage #(
   parameter int unsigned LEN_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart,
   input  logic             adv_in,
   input  logic             bypass,
   input  logic             start_hi,
   input  logic [LEN_W-1:0] low_n,
   input  logic [LEN_W-1:0] high_n,
   output logic             lvl_o,
   output logic             rise_o
);
   localparam logic [LEN_W-1:0] ONE = {{(LEN_W-1){1'b0}}, 1'b1};

   logic [LEN_W-1:0] cnt_q;
   logic             lvl_q;
   logic             tgl_q;
   logic [LEN_W-1:0] limit;
   logic             at_end;

   // current half-period length depends on the level being held
   always_comb begin
      limit  = lvl_q ? high_n : low_n;
      at_end = (cnt_q == limit);
   end

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         cnt_q <= '0;
         lvl_q <= start_hi;
         tgl_q <= start_hi;
      end else if (adv_in) begin
         if (bypass) begin
            tgl_q <= ~tgl_q;
         end else if (at_end) begin
            lvl_q <= ~lvl_q;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + ONE;
         end
      end
   end

   always_comb begin
      lvl_o  = bypass ? tgl_q : lvl_q;
      rise_o = !rst && !restart && adv_in &&
               (bypass ? !tgl_q : (!lvl_q && at_end));
   end
endmodule

// File: rtl/casc_div_ctrl.sv
module casc_div_ctrl (
   input  logic sync_in,
   input  logic sync_ignore,
   input  logic hold_en,
   input  logic hold_level,
   input  logic last_lvl,
   input  logic last_rise,
   output logic restart,
   output logic div_out,
   output logic div_rise
);
   logic holding;

   always_comb begin
      restart  = sync_in && !sync_ignore;
      holding  = sync_ignore && hold_en;
      div_out  = holding ? hold_level : last_lvl;
      div_rise = !holding && last_rise;
   end
endmodule

// File: rtl/casc_clk_divider.sv
module casc_clk_divider
   import casc_div_pkg::*;
#(
   parameter int unsigned NUM_STAGES = 2,
   parameter int unsigned CNT_W      = 4
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        sync_in,
   input  logic                        sync_ignore,
   input  logic                        hold_en,
   input  logic                        hold_level,
   input  logic [NUM_STAGES*CNT_W-1:0] low_len,
   input  logic [NUM_STAGES*CNT_W-1:0] high_len,
   input  logic [NUM_STAGES-1:0]       start_level,
   input  logic [NUM_STAGES-1:0]       stage_bypass,
   output logic                        div_out,
   output logic                        div_rise
);
   localparam int unsigned LAST = NUM_STAGES - 1;

   if (CNT_W < MIN_LEN_W) begin : g_bad_w
      $error("CNT_W must be at least %0d", MIN_LEN_W);
   end
   if (NUM_STAGES < MIN_STAGES) begin : g_bad_n
      $error("NUM_STAGES must be at least %0d", MIN_STAGES);
   end

   logic [NUM_STAGES-1:0] adv;
   logic [NUM_STAGES-1:0] rise;
   logic                  restart;
   logic                  last_lvl;
   logic                  last_adv;
   logic                  last_byp;
   logic                  last_start;

   assign adv[0] = 1'b1;

   for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
      localparam int unsigned LSB = fld_lsb(g, CNT_W);
      logic lvl;

      casc_div_stage #(.LEN_W(CNT_W)) u_stage (
         .clk      (clk),
         .rst      (rst),
         .restart  (restart),
         .adv_in   (adv[g]),
         .bypass   (stage_bypass[g]),
         .start_hi (start_level[g]),
         .low_n    (low_len[LSB +: CNT_W]),
         .high_n   (high_len[LSB +: CNT_W]),
         .lvl_o    (lvl),
         .rise_o   (rise[g])
      );

      if (g < LAST) begin : g_link
         logic mid_lvl_unused;
         assign mid_lvl_unused = lvl;
         // a bypassed stage forwards its advance pulse unchanged
         assign adv[g+1] = stage_bypass[g] ? adv[g] : rise[g];
      end else begin : g_tail
         assign last_lvl = lvl;
      end
   end

   assign last_adv   = adv[LAST];
   assign last_byp   = stage_bypass[LAST];
   assign last_start = start_level[LAST];

   casc_div_ctrl u_ctrl (
      .sync_in     (sync_in),
      .sync_ignore (sync_ignore),
      .hold_en     (hold_en),
      .hold_level  (hold_level),
      .last_lvl    (last_lvl),
      .last_rise   (rise[LAST]),
      .restart     (restart),
      .div_out     (div_out),
      .div_rise    (div_rise)
   );
endmodule

// File: rtl/casc_clk_divider_chk.sv
module casc_clk_divider_chk (
   input logic clk,
   input logic rst,
   input logic sync_in,
   input logic sync_ignore,
   input logic hold_en,
   input logic hold_level,
   input logic start_last,
   input logic bypass_last,
   input logic div_out,
   input logic div_rise,
   input logic last_lvl,
   input logic last_adv,
   input logic restart
);
   // R5
   sync_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (sync_in && !sync_ignore) |=> (last_lvl == $past(start_last)));

   // R7
   hold_static_chk: assert property (@(posedge clk) disable iff (rst)
      (sync_ignore && hold_en && $past(sync_ignore && hold_en) && $stable(hold_level))
         |-> $stable(div_out));

   // R10
   rise_level_chk: assert property (@(posedge clk) disable iff (rst)
      div_rise |=> (last_lvl || !$stable(bypass_last)));

   // R3
   idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (!last_adv && !restart) |=> ($stable(last_lvl) || !$stable(bypass_last)));
endmodule

bind casc_clk_divider casc_clk_divider_chk u_chk (
   .clk         (clk),
   .rst         (rst),
   .sync_in     (sync_in),
   .sync_ignore (sync_ignore),
   .hold_en     (hold_en),
   .hold_level  (hold_level),
   .start_last  (last_start),
   .bypass_last (last_byp),
   .div_out     (div_out),
   .div_rise    (div_rise),
   .last_lvl    (last_lvl),
   .last_adv    (last_adv),
   .restart     (restart)
);

// File: tb/sim_casc_clk_divider.sv
`timescale 1ns/1ps
module sim_casc_clk_divider;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sync_in = 1'b0;
   logic       sync_ignore = 1'b0;
   logic       hold_en = 1'b0;
   logic       hold_level = 1'b0;
   logic [7:0] low_len = '0;
   logic [7:0] high_len = '0;
   logic [1:0] start_level = '0;
   logic [1:0] stage_bypass = '0;
   logic       div_out;
   logic       div_rise;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   casc_clk_divider #(.NUM_STAGES(2), .CNT_W(4)) u0 (
      .clk(clk), .rst(rst), .sync_in(sync_in), .sync_ignore(sync_ignore),
      .hold_en(hold_en), .hold_level(hold_level), .low_len(low_len),
      .high_len(high_len), .start_level(start_level), .stage_bypass(stage_bypass),
      .div_out(div_out), .div_rise(div_rise)
   );

   typedef struct packed {
      logic [3:0]  l1, h1, l2, h2;
      logic        b1, b2;
      logic [15:0] per, hi;
   } vec_t;

   // expected values from R3, R8, R9
   localparam vec_t VECS [8] = '{
      '{4'd0,  4'd0,  4'd0,  4'd0,  1'b0, 1'b0, 16'd4,    16'd2},
      '{4'd2,  4'd1,  4'd1,  4'd2,  1'b0, 1'b0, 16'd25,   16'd15},
      '{4'd15, 4'd15, 4'd15, 4'd15, 1'b0, 1'b0, 16'd1024, 16'd512},
      '{4'd3,  4'd0,  4'd0,  4'd4,  1'b0, 1'b0, 16'd30,   16'd25},
      '{4'd0,  4'd7,  4'd5,  4'd0,  1'b0, 1'b0, 16'd63,   16'd9},
      '{4'd9,  4'd9,  4'd2,  4'd1,  1'b1, 1'b0, 16'd5,    16'd2},
      '{4'd1,  4'd2,  4'd7,  4'd7,  1'b0, 1'b1, 16'd10,   16'd5},
      '{4'd3,  4'd3,  4'd3,  4'd3,  1'b1, 1'b1, 16'd2,    16'd1}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_cfg(input logic [3:0] l1, h1, l2, h2,
                          input logic b1, b2, s1, s2);
      low_len      = {l2, l1};
      high_len     = {h2, h1};
      stage_bypass = {b2, b1};
      start_level  = {s2, s1};
   endtask

   task automatic pulse_sync();
      @(negedge clk) sync_in = 1'b1;
      @(negedge clk) sync_in = 1'b0;
   endtask

   // measures high time and period from one output rise to the next
   task automatic measure(output int per, output int hi, output bit rise_ok);
      bit prev, prev_r, cur;
      int t, t_r0, t_f;
      int phase;
      per = -1; hi = -1; rise_ok = 1'b1; phase = 0; t_r0 = 0; t_f = 0;
      @(negedge clk);
      prev = div_out; prev_r = div_rise;
      for (t = 1; t < 5000 && phase < 3; t++) begin
         @(negedge clk);
         cur = div_out;
         if (prev_r != (!prev && cur)) rise_ok = 1'b0;
         if (!prev && cur) begin
            if (phase == 0) begin t_r0 = t; phase = 1; end
            else if (phase == 2) begin per = t - t_r0; phase = 3; end
         end else if (prev && !cur && phase == 1) begin
            t_f = t; hi = t_f - t_r0; phase = 2;
         end
         prev = cur; prev_r = div_rise;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "watchdog R3", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int per, hi, cnt;
      bit rok, ok;
      // reset state, start level high on the last stage
      set_cfg(4'd0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1);
      repeat (3) @(negedge clk);
      check(div_out == 1'b1, "R4 reset level high", div_out, 1);
      check(div_rise == 1'b0, "R10 no rise in reset", div_rise, 0);
      start_level = 2'b00;
      @(negedge clk);
      @(negedge clk);
      check(div_out == 1'b0, "R4 reset level low", div_out, 0);
      rst = 1'b0;

      // table walk
      foreach (VECS[i]) begin
         string tag;
         set_cfg(VECS[i].l1, VECS[i].h1, VECS[i].l2, VECS[i].h2,
                 VECS[i].b1, VECS[i].b2, 1'b0, 1'b0);
         tag = VECS[i].b1 ? "R8" : (VECS[i].b2 ? "R9" : "R3");
         pulse_sync();
         measure(per, hi, rok);
         check(per == int'(VECS[i].per), $sformatf("%s period vec%0d", tag, i), per, VECS[i].per);
         check(hi == int'(VECS[i].hi), $sformatf("R2 high time vec%0d", i), hi, VECS[i].hi);
         check(per - hi == int'(VECS[i].per) - int'(VECS[i].hi),
               $sformatf("R1 low time vec%0d", i), per - hi, VECS[i].per - VECS[i].hi);
         check(rok, $sformatf("R10 rise pulse vec%0d", i), rok, 1);
      end

      // first high interval after restart with a high start level: 3 + 2*5 = 13
      set_cfg(4'd2, 4'd1, 4'd1, 4'd2, 1'b0, 1'b0, 1'b0, 1'b1);
      @(negedge clk) sync_in = 1'b1;
      @(negedge clk);
      check(div_out == 1'b1, "R4 start level after restart", div_out, 1);
      sync_in = 1'b0;
      cnt = 1;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         if (div_out) cnt++;
         else break;
      end
      check(cnt == 13, "R3 first high interval", cnt, 13);

      // restart held: output frozen at start level, then resumes at once
      set_cfg(4'd0, 4'd0, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0);
      @(negedge clk) sync_in = 1'b1;
      ok = 1'b1;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (div_out !== 1'b0) ok = 1'b0;
      end
      check(ok, "R5 held during restart", ok, 1);
      sync_in = 1'b0;
      @(negedge clk);
      check(div_out == 1'b1, "R5 resumes first edge", div_out, 1);

      // restart ignored
      sync_ignore = 1'b1;
      @(negedge clk) sync_in = 1'b1;
      measure(per, hi, rok);
      check(per == 4, "R6 restart ignored period", per, 4);
      sync_in = 1'b0;

      // hold high, then hold low
      hold_en = 1'b1; hold_level = 1'b1;
      ok = 1'b1;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         if (div_out !== 1'b1 || div_rise !== 1'b0) ok = 1'b0;
      end
      check(ok, "R7 hold high", ok, 1);
      hold_level = 1'b0;
      ok = 1'b1;
      for (int k = 0; k < 30; k++) begin
         @(negedge clk);
         if (div_out !== 1'b0 || div_rise !== 1'b0) ok = 1'b0;
      end
      check(ok, "R7 hold low", ok, 1);

      // hold request without ignore has no effect
      sync_ignore = 1'b0;
      pulse_sync();
      measure(per, hi, rok);
      check(per == 4, "R7 hold needs ignore bit", per, 4);
      hold_en = 1'b0;

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule